// File: doc/BRIEF.md
# Synchronous FIFO with Threshold Flags

A single-clock first-in first-out buffer. Pushes and pops are sampled on the same rising edge. The data width and the storage depth are set by parameters. The depth must be a power of two and at least 4, so that the quarter and three-quarter occupancy levels are whole numbers.

Besides full and empty, the block reports a near-full flag at three-quarters occupancy and a near-empty flag at one-quarter occupancy. It also gives the occupancy count itself. An illegal operation, meaning a push into a full buffer or a pop from an empty one, is dropped and leaves the stored data unchanged. It also raises a misuse pulse on the following cycle. Every output comes from a register, and the storage is written so that it maps onto a simple dual-port block RAM. Reset is synchronous and active high.

Top module: `sync_fifo_thr`

## Requirements
- R1: On a rising edge with `rst` high, `level` becomes 0, `is_empty` and `near_empty` become 1, `is_full`, `near_full` and `misuse` become 0, and `rd_data` becomes 0.
- R2: Data leaves in the order it was accepted, including after the pointers wrap past the depth. `rd_data` takes the popped word on the edge that accepts the pop and holds its value on every edge without an accepted pop.
- R3: A push while `is_full` is 1 and `pop` is 0 is dropped. `level` stays at DEPTH, and the words popped afterwards are the original contents.
- R4: A pop while `is_empty` is 1 and `push` is 0 is dropped. `level` stays at 0 and `rd_data` keeps its value.
- R5: `misuse` is 1 in the cycle after an edge on which (`push` and `is_full`) or (`pop` and `is_empty`) held. It is 0 after every other edge.
- R6: A push and a pop on the same edge, with the buffer neither full nor empty, are both performed, and `level` is unchanged.
- R7: A push and a pop on the same edge with the buffer full perform only the pop, so `level` becomes DEPTH-1. With the buffer empty they perform only the push, so `level` becomes 1. Both cases raise `misuse`.
- R8: `level` is $clog2(DEPTH)+1 bits wide. It equals the number of stored words (0 to DEPTH) after each edge.
- R9: `is_full` is 1 exactly when `level` equals DEPTH, and `is_empty` is 1 exactly when `level` is 0.
- R10: `near_full` is 1 exactly when `level` is at least 3*DEPTH/4.
- R11: `near_empty` is 1 exactly when `level` is at most DEPTH/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both pushes and pops |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request for `wr_data` |
| pop | input | 1 | Read request for the oldest word |
| wr_data | input | WIDTH | Data to store |
| rd_data | output | WIDTH | Registered oldest word, updated after an accepted pop |
| is_full | output | 1 | Occupancy equals DEPTH |
| is_empty | output | 1 | Occupancy is zero |
| near_full | output | 1 | Occupancy at or above 3/4 of DEPTH |
| near_empty | output | 1 | Occupancy at or below 1/4 of DEPTH |
| misuse | output | 1 | Pulse after a dropped push or pop |
| level | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
The properties assume that `push`, `pop` and `rst` hold known, settled values at each rising edge. They place no limit on the request pattern, because pushing into a full buffer and popping from an empty one are defined behaviour with their own pulse. The bench changes every input on the falling edge only, and it deliberately drives all four push/pop combinations at the empty, full and intermediate levels. A long pseudo-random phase with fill-biased and drain-biased stretches then pushes the pointers through many wraps while the thresholds toggle.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;

  // Registered status bundle shared by flag logic and control logic
  typedef struct packed {
    logic full;
    logic empty;
    logic hi;
    logic lo;
  } fifo_flags_t;

  localparam fifo_flags_t FLAGS_RESET = '{full: 1'b0, empty: 1'b1, hi: 1'b0, lo: 1'b1};

endpackage

// File: rtl/fifo_thr_ram.sv
module fifo_thr_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  // Write port: no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Synchronous read port with an enable; the output register is reset
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/fifo_thr_flags.sv
module fifo_thr_flags
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_nxt,
  output fifo_flags_t   flags
);

  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_HI   = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] LVL_LO   = CW'(DEPTH / 4);

  fifo_flags_t flags_d;
  fifo_flags_t flags_q;

  // Flags decoded from the next occupancy so they line up with the count register
  always_comb begin
    flags_d.full  = (count_nxt == LVL_FULL);
    flags_d.empty = (count_nxt == '0);
    flags_d.hi    = (count_nxt >= LVL_HI);
    flags_d.lo    = (count_nxt <= LVL_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= FLAGS_RESET;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/fifo_thr_ctrl.sv
module fifo_thr_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          full,
  input  logic          empty,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] count_nxt,
  output logic          misuse_q
);

  logic [AW-1:0] wptr_q;
  logic [AW-1:0] rptr_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          err_d;

  // Accept decisions use the registered flags, not a fresh compare
  assign wr_en = push & ~full;
  assign rd_en = pop & ~empty;
  assign err_d = (push & full) | (pop & empty);

  always_comb begin
    unique case ({wr_en, rd_en})
      2'b10:   count_nxt = cnt_q + CW'(1);
      2'b01:   count_nxt = cnt_q - CW'(1);
      default: count_nxt = cnt_q;
    endcase
  end

  // Pointers wrap naturally because DEPTH is a power of two
  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en) wptr_q <= wptr_q + AW'(1);
      if (rd_en) rptr_q <= rptr_q + AW'(1);
      cnt_q <= count_nxt;
      err_q <= err_d;
    end
  end

  assign wr_addr  = wptr_q;
  assign rd_addr  = rptr_q;
  assign count_q  = cnt_q;
  assign misuse_q = err_q;

endmodule

// File: rtl/sync_fifo_thr.sv
module sync_fifo_thr
  import fifo_thr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             is_full,
  output logic             is_empty,
  output logic             near_full,
  output logic             near_empty,
  output logic             misuse,
  output logic [CW-1:0]    level
);

  logic          wr_en;
  logic          rd_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] count_nxt;
  fifo_flags_t   flags;

  fifo_thr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .full      (flags.full),
    .empty     (flags.empty),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .count_q   (level),
    .count_nxt (count_nxt),
    .misuse_q  (misuse)
  );

  fifo_thr_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .count_nxt (count_nxt),
    .flags     (flags)
  );

  fifo_thr_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign is_full    = flags.full;
  assign is_empty   = flags.empty;
  assign near_full  = flags.hi;
  assign near_empty = flags.lo;

endmodule

// File: rtl/fifo_thr_chk.sv
module fifo_thr_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic             is_full,
  input logic             is_empty,
  input logic             near_full,
  input logic             near_empty,
  input logic             misuse,
  input logic [CW-1:0]    level
);

  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_HI   = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] LVL_LO   = CW'(DEPTH / 4);

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (level == '0) && is_empty && near_empty && !is_full && !near_full && !misuse && (rd_data == '0)); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !(pop && !is_empty) |=> $stable(rd_data)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (push && is_full && !pop) |=> (level == LVL_FULL)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) (pop && is_empty && !push) |=> (level == '0) && $stable(rd_data)); // R4
  AST_MISUSE_SET: assert property (@(posedge clk) disable iff (rst) ((push && is_full) || (pop && is_empty)) |=> misuse); // R5
  AST_MISUSE_CLR: assert property (@(posedge clk) disable iff (rst) !((push && is_full) || (pop && is_empty)) |=> !misuse); // R5
  AST_BOTH_MID: assert property (@(posedge clk) disable iff (rst) (push && pop && !is_full && !is_empty) |=> $stable(level)); // R6
  AST_BOTH_FULL: assert property (@(posedge clk) disable iff (rst) (push && pop && is_full) |=> (level == LVL_FULL - CW'(1))); // R7
  AST_BOTH_EMPTY: assert property (@(posedge clk) disable iff (rst) (push && pop && is_empty) |=> (level == CW'(1))); // R7
  AST_LEVEL_UP: assert property (@(posedge clk) disable iff (rst) (push && !pop && !is_full) |=> (level == $past(level) + CW'(1))); // R8
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst) level <= LVL_FULL); // R8
  AST_FULL_EMPTY: assert property (@(posedge clk) disable iff (rst) (is_full == (level == LVL_FULL)) && (is_empty == (level == '0))); // R9
  AST_NEAR_FULL: assert property (@(posedge clk) disable iff (rst) near_full == (level >= LVL_HI)); // R10
  AST_NEAR_EMPTY: assert property (@(posedge clk) disable iff (rst) near_empty == (level <= LVL_LO)); // R11

endmodule

bind sync_fifo_thr fifo_thr_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sync_fifo_thr_tb.sv
module sync_fifo_thr_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int D  = 8;
  localparam int CW = $clog2(D) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;
  logic          is_full, is_empty, near_full, near_empty, misuse;
  logic [CW-1:0] level;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mq[$];
  logic [W-1:0] rd_exp = '0;
  logic         mis_exp = 1'b0;
  logic [15:0]  lfsr = 16'hACE1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_fifo_thr #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .wr_data(wr_data),
    .rd_data(rd_data), .is_full(is_full), .is_empty(is_empty),
    .near_full(near_full), .near_empty(near_empty), .misuse(misuse), .level(level)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    int n;
    n = mq.size();
    chk(int'(level) == n, "R8 level", int'(level), n);
    chk(is_full == (n == D), "R9 full", int'(is_full), int'(n == D));
    chk(is_empty == (n == 0), "R9 empty", int'(is_empty), int'(n == 0));
    chk(near_full == (n >= (3 * D) / 4), "R10 near_full", int'(near_full), int'(n >= (3 * D) / 4));
    chk(near_empty == (n <= D / 4), "R11 near_empty", int'(near_empty), int'(n <= D / 4));
    chk(misuse == mis_exp, "R5 misuse", int'(misuse), int'(mis_exp));
    chk(rd_data == rd_exp, "R2 rd_data", int'(rd_data), int'(rd_exp));
  endtask

  // Drive on the falling edge, update the model, sample 1 time unit after the rising edge
  task automatic step(input logic p, input logic q, input logic [W-1:0] d);
    bit fm, em;
    @(negedge clk);
    push = p; pop = q; wr_data = d;
    fm = (mq.size() == D);
    em = (mq.size() == 0);
    mis_exp = (p && fm) || (q && em);
    if (q && !em) rd_exp = mq.pop_front();
    if (p && !fm) mq.push_back(d);
    @(posedge clk);
    #1;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; push = 1'b0; pop = 1'b0;
    @(posedge clk);
    #1;
    mq.delete();
    rd_exp = '0;
    mis_exp = 1'b0;
    chk(level == '0, "R1 level", int'(level), 0);
    chk(is_empty && near_empty, "R1 empty flags", int'({is_empty, near_empty}), 3);
    chk(!is_full && !near_full && !misuse, "R1 full/misuse", int'({is_full, near_full, misuse}), 0);
    chk(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    do_reset();

    // R10 R11: fill sweep through every occupancy level
    for (int i = 0; i < D; i++) step(1'b1, 1'b0, W'(8'h10 + i));

    // R3: push while full is dropped
    step(1'b1, 1'b0, 8'hEE);
    chk(int'(level) == D, "R3 level held at DEPTH", int'(level), D);

    // R7: push+pop when full -> pop only
    step(1'b1, 1'b1, 8'hDD);
    chk(int'(level) == D - 1 && misuse, "R7 full both", int'(level), D - 1);

    // R6: push+pop mid-level keeps level
    step(1'b1, 1'b1, 8'h55);
    chk(int'(level) == D - 1, "R6 level unchanged", int'(level), D - 1);

    // R2 R3: drain sweep; original contents come out in order
    for (int i = 0; i < D - 1; i++) step(1'b0, 1'b1, '0);
    chk(rd_data == 8'h55, "R2 last word", int'(rd_data), 8'h55);

    // R4: pop while empty is dropped, rd_data holds
    held = rd_data;
    step(1'b0, 1'b1, '0);
    chk(level == '0 && rd_data == held, "R4 empty pop", int'(rd_data), int'(held));
    step(1'b0, 1'b0, '0);
    chk(!misuse, "R5 misuse one cycle", int'(misuse), 0);

    // R7: push+pop when empty -> push only
    step(1'b1, 1'b1, 8'hA7);
    chk(int'(level) == 1 && misuse, "R7 empty both", int'(level), 1);
    step(1'b0, 1'b1, '0);
    chk(rd_data == 8'hA7, "R7 pushed word kept", int'(rd_data), 8'hA7);

    // R1: reset from a partly filled state
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, W'(i));
    do_reset();

    // R2 R8: pseudo-random stream with fill and drain bias, many pointer wraps
    for (int i = 0; i < 4000; i++) begin
      bit p, q;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if ((i / 200) % 2 == 0) begin
        p = lfsr[1:0] != 2'b00;
        q = lfsr[3:2] == 2'b00;
      end else begin
        p = lfsr[3:2] == 2'b00;
        q = lfsr[1:0] != 2'b00;
      end
      step(p, q, lfsr[W+3:4]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule